// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block paces the instruction stream of a small 8-bit microcontroller core whose program words are 13 bits wide. It runs directly on the oscillator clock and groups oscillator periods into instruction cycles. A cycle is two periods long or four, set by a static option input. The option is captured while reset is held and is not read again after that.

The core's decoder reports five redirect conditions: an unconditional jump, a call, any return-type instruction, a conditional skip whose test came out true, and an arithmetic, logic or move operation whose destination is the program-counter register. When any of these is present on the last oscillator period of a normal cycle, the sequencer makes the next instruction cycle a bubble. During a bubble the word already fetched is discarded (flush high) and execution is disabled for the whole cycle. The block also gives a one-clock strobe at the start of every cycle and a timer tick once per cycle, so the timer advances at the instruction-cycle rate.

Top module: `instr_cycle_seq`

## Requirements
- R1: With `long_cyc_i` low during reset, every instruction cycle lasts exactly two clock periods.
- R2: With `long_cyc_i` high during reset, every instruction cycle lasts exactly four clock periods.
- R3: `long_cyc_i` is sampled only while `rst_ni` is low. Changing it after reset is released does not change the cycle length.
- R4: `cyc_start_o` is high for exactly the first clock period of every cycle, bubble cycles included. The first cycle begins on the first rising edge after reset is released.
- R5: `tmr_tick_o` is high for exactly one clock period per cycle, and that period is the cycle's last.
- R6: If `jump_i`, `call_i`, `ret_i` or `pc_wr_i` is high on the last period of a normal cycle, the next cycle is a bubble: `flush_o` is high and `exec_en_o` is low for all of its periods. The cycle after the bubble is normal.
- R7: `skip_taken_i` high on the last period of a normal cycle inserts a bubble in the same way. A skip that did not trigger leaves the input low, and no bubble follows.
- R8: Redirect inputs are sampled only on the last period of a cycle. Pulses on earlier periods have no effect.
- R9: Redirect inputs seen during a bubble cycle are ignored, so two bubbles never follow each other.
- R10: While `rst_ni` is low, all four outputs are low. Reset clears the phase position and any pending bubble, so the first cycle after reset is normal.
- R11: In a normal cycle, `exec_en_o` is high and `flush_o` is low for every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| long_cyc_i | input | 1 | Cycle-length option: 0 gives two periods, 1 gives four; sampled during reset |
| jump_i | input | 1 | Decoded unconditional jump |
| call_i | input | 1 | Decoded call |
| ret_i | input | 1 | Decoded return, return with literal, or return from interrupt |
| skip_taken_i | input | 1 | Conditional skip whose test was true |
| pc_wr_i | input | 1 | ALU or move operation writing the program counter |
| cyc_start_o | output | 1 | One-clock strobe on the first period of each cycle |
| exec_en_o | output | 1 | High through a normal cycle |
| flush_o | output | 1 | High through a bubble cycle; the fetched word is discarded |
| tmr_tick_o | output | 1 | Timer tick on the last period of each cycle |

## Verification
The bench sends each of the five redirect inputs through both cycle lengths. A design that missed one of them would fail to flush, and the next word would execute. A redirect held high across the bubble checks for a design that re-samples during the bubble and stalls forever in back-to-back bubbles. A redirect that pulses only on an early period checks for a design that samples the wrong phase. The bench also flips the option after reset to catch a design that reads it live and changes cycle length. Finally, it resets in the middle of a bubble to catch a design whose stale bubble survives reset.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    RD_JUMP = 3'd0,
    RD_CALL = 3'd1,
    RD_RET  = 3'd2,
    RD_SKIP = 3'd3,
    RD_PCWR = 3'd4
  } redir_e;
  localparam int unsigned N_REDIR = 5;
endpackage

// File: rtl/isq_phase_ctr.sv
module isq_phase_ctr #(
  parameter int unsigned SHORT_LEN = 2,
  parameter int unsigned LONG_LEN  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_sel_i,
  output logic run_o,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned PH_W = (LONG_LEN > 2) ? $clog2(LONG_LEN) : 1;

  logic            long_q;
  logic            run_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] lim;
  logic            at_lim;

  // option captured only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) long_q <= long_sel_i;
  end

  always_comb begin
    lim    = long_q ? PH_W'(LONG_LEN - 1) : PH_W'(SHORT_LEN - 1);
    at_lim = (ph_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) ph_q <= at_lim ? '0 : ph_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign first_o = run_q && (ph_q == '0);
  assign last_o  = run_q && at_lim;

  AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> !first_o); // R4
  AST_TICK_THEN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> first_o); // R5
  AST_OPTION_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(long_q)); // R3
  AST_SHORT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !long_q) |-> (ph_q <= PH_W'(SHORT_LEN - 1))); // R1
endmodule

// File: rtl/isq_bubble_ctl.sv
module isq_bubble_ctl #(
  parameter int unsigned N_FLAGS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               last_i,
  input  logic [N_FLAGS-1:0] redir_i,
  output logic               exec_en_o,
  output logic               flush_o
);
  logic bub_q;
  logic any_redir;

  assign any_redir = |redir_i;

  // decision taken at cycle end; a bubble never arms another bubble
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              bub_q <= 1'b0;
    else if (run_i && last_i) bub_q <= !bub_q && any_redir;
  end

  assign exec_en_o = run_i && !bub_q;
  assign flush_o   = run_i && bub_q;

  AST_REDIR_BUBBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && exec_en_o && any_redir) |=> flush_o); // R6
  AST_FLUSH_WHOLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !last_i) |=> flush_o); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && last_i) |=> exec_en_o); // R9
  AST_EARLY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en_o && !last_i) |=> exec_en_o); // R8
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq #(
  parameter int unsigned SHORT_LEN = 2,
  parameter int unsigned LONG_LEN  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_cyc_i,
  input  logic jump_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic skip_taken_i,
  input  logic pc_wr_i,
  output logic cyc_start_o,
  output logic exec_en_o,
  output logic flush_o,
  output logic tmr_tick_o
);
  import isq_pkg::*;

  logic               run;
  logic               first;
  logic               last;
  logic [N_REDIR-1:0] redir;

  always_comb begin
    redir          = '0;
    redir[RD_JUMP] = jump_i;
    redir[RD_CALL] = call_i;
    redir[RD_RET]  = ret_i;
    redir[RD_SKIP] = skip_taken_i;
    redir[RD_PCWR] = pc_wr_i;
  end

  isq_phase_ctr #(
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .long_sel_i (long_cyc_i),
    .run_o      (run),
    .first_o    (first),
    .last_o     (last)
  );

  isq_bubble_ctl #(
    .N_FLAGS (N_REDIR)
  ) u_bubble (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .last_i    (last),
    .redir_i   (redir),
    .exec_en_o (exec_en_o),
    .flush_o   (flush_o)
  );

  assign cyc_start_o = first;
  assign tmr_tick_o  = last;

  AST_EXEC_XOR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> (exec_en_o ^ flush_o)); // R11
endmodule

// File: tb/instr_cycle_seq_tb.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic long_cyc_i = 1'b0;
  logic jump_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, skip_taken_i = 1'b0, pc_wr_i = 1'b0;
  logic cyc_start_o, exec_en_o, flush_o, tmr_tick_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i; // 250 MHz

  instr_cycle_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .long_cyc_i(long_cyc_i),
    .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
    .skip_taken_i(skip_taken_i), .pc_wr_i(pc_wr_i),
    .cyc_start_o(cyc_start_o), .exec_en_o(exec_en_o),
    .flush_o(flush_o), .tmr_tick_o(tmr_tick_o)
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  // flag order: jump, call, ret, skip, pc write
  task automatic set_flags(input logic [4:0] f);
    {pc_wr_i, skip_taken_i, ret_i, call_i, jump_i} = f;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {start,exec,flush,tick} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Starts in period 0 of a cycle, leaves in period 0 of the next.
  task automatic run_cycle(input string req, input bit norm, input int len, input bit clr_early);
    for (int i = 0; i < len; i++) begin
      chk(req, {cyc_start_o, exec_en_o, flush_o, tmr_tick_o},
          {1'(i == 0), norm, !norm, 1'(i == len - 1)});
      if (clr_early && i == 0) set_flags(5'b0);
      step();
    end
  endtask

  task automatic do_reset(input logic long_sel);
    rst_ni = 1'b0;
    long_cyc_i = long_sel;
    set_flags(5'b0);
    step();
    step();
    chk("R10 reset outputs", {cyc_start_o, exec_en_o, flush_o, tmr_tick_o}, 4'b0000);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_short_len();
    do_reset(1'b0);
    for (int c = 0; c < 3; c++) run_cycle("R1 R4 R5 R11 short cycle", 1'b1, 2, 1'b0);
  endtask

  task automatic t_long_len();
    do_reset(1'b1);
    for (int c = 0; c < 3; c++) run_cycle("R2 R4 R5 R11 long cycle", 1'b1, 4, 1'b0);
  endtask

  task automatic t_each_redir(input logic long_sel);
    int len = long_sel ? 4 : 2;
    do_reset(long_sel);
    for (int f = 0; f < 5; f++) begin
      set_flags(5'b1 << f);
      run_cycle((f == 3) ? "R7 skip taken" : "R6 redirect", 1'b1, len, 1'b0);
      set_flags(5'b0);
      run_cycle((f == 3) ? "R7 skip bubble" : "R6 bubble", 1'b0, len, 1'b0);
      run_cycle("R6 after bubble", 1'b1, len, 1'b0);
    end
    run_cycle("R7 skip not taken", 1'b1, len, 1'b0);
    run_cycle("R7 no bubble", 1'b1, len, 1'b0);
  endtask

  task automatic t_early_pulse();
    do_reset(1'b1);
    set_flags(5'b00001);
    run_cycle("R8 early pulse cycle", 1'b1, 4, 1'b1);
    run_cycle("R8 early pulse ignored", 1'b1, 4, 1'b0);
  endtask

  task automatic t_hold_through_bubble(input logic long_sel);
    int len = long_sel ? 4 : 2;
    do_reset(long_sel);
    set_flags(5'b10000);
    run_cycle("R9 arm", 1'b1, len, 1'b0);
    run_cycle("R9 bubble with flag held", 1'b0, len, 1'b0);
    set_flags(5'b0);
    run_cycle("R9 no second bubble", 1'b1, len, 1'b0);
  endtask

  task automatic t_option_late();
    do_reset(1'b0);
    long_cyc_i = 1'b1;
    for (int c = 0; c < 3; c++) run_cycle("R3 option ignored after reset", 1'b1, 2, 1'b0);
    long_cyc_i = 1'b0;
  endtask

  task automatic t_reset_mid_bubble();
    do_reset(1'b1);
    set_flags(5'b00100);
    run_cycle("R10 arm", 1'b1, 4, 1'b0);
    set_flags(5'b0);
    step();
    chk("R10 in bubble", {cyc_start_o, exec_en_o, flush_o, tmr_tick_o}, 4'b0010);
    do_reset(1'b1);
    run_cycle("R10 normal after reset", 1'b1, 4, 1'b0);
  endtask

  initial begin
    t_short_len();
    t_long_len();
    t_each_redir(1'b0);
    t_each_redir(1'b1);
    t_early_pulse();
    t_hold_through_bubble(1'b0);
    t_hold_through_bubble(1'b1);
    t_option_late();
    t_reset_mid_bubble();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule